// File: doc/BRIEF.md
# Strap Latch and LED Status Driver

This block shares five bidirectional pads between two jobs. While reset is held it only listens: it records the level on each pad and keeps the five levels as a management address, with pad 0 as the least significant bit. In the same reset window it records four separate mode straps: line speed, duplex, auto-negotiation enable and MAC interface type. Once reset has ended and one more clock has passed, it turns the five pads into outputs and uses them as status LEDs.

Each pad takes its LED polarity from the level recorded on it. A pad that was strapped high sinks current to light its LED, so a lit LED drives it low. A pad that was strapped low lights its LED by driving high. Pads 0 and 1 show the link state and full-duplex state without blinking. Pads 2, 3 and 4 are driven by blink timers. The timer on pad 2 starts on 10 Mb/s activity, the one on pad 3 on 100 Mb/s activity, and the one on pad 4 on collisions. Each timer keeps its LED lit for a set number of clocks, then keeps it dark for the same number of clocks before it accepts a new trigger.

Top module: `strap_led_ctrl`

## Requirements
- R1: `mgmt_addr[i]` holds the level that `pad_in[i]` had at the last rising clock edge with `rst_n` low, for i = 0..4. Bit 0 is the least significant bit of the address.
- R2: `cfg_speed100`, `cfg_full_dup`, `cfg_aneg_en` and `cfg_mii_mode` hold the levels of their strap inputs at the last rising edge with `rst_n` low. A 1 selects 100 Mb/s, full duplex, auto-negotiation and MII. A 0 selects 10 Mb/s, half duplex, forced mode and the serial interface.
- R3: `pad_oe` is 5'b00000 throughout reset and through the first rising edge after `rst_n` goes high. It becomes 5'b11111 at the second rising edge after release.
- R4: For each pad, `pad_out[i]` equals the pad's lit state XOR `mgmt_addr[i]`. A pad latched at 1 therefore drives 0 when its LED is lit, and a pad latched at 0 drives 1 when lit.
- R5: Pad 0 is lit exactly while `link_up` is 1, and pad 1 is lit exactly while `full_dup` is 1. Both follow their inputs in the same cycle and never blink.
- R6: When `activity` is sampled high, it triggers the pad 2 timer if `speed_100` is 0, or the pad 3 timer if `speed_100` is 1. The other timer is not affected.
- R7: A trigger sampled while a timer is idle lights its pad for `BLINK_TICKS` cycles, starting right after that edge. A trigger sampled while the pad is lit restarts the lit period. After the lit period the pad stays dark for `BLINK_TICKS` cycles, and triggers that arrive in the dark period are ignored.
- R8: When `collision` is sampled high, it triggers the pad 4 timer, which follows the timing of R7.
- R9: After reset, `mgmt_addr` and the four `cfg_*` outputs do not change, whatever happens on `pad_in` or on the strap inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| pad_in | input | 5 | Levels read back from the five shared pads |
| speed_strap | input | 1 | Speed strap level |
| duplex_strap | input | 1 | Duplex strap level |
| aneg_strap | input | 1 | Auto-negotiation enable strap level |
| ifmode_strap | input | 1 | Interface mode strap level |
| link_up | input | 1 | Link is up |
| full_dup | input | 1 | Port is operating in full duplex |
| speed_100 | input | 1 | 1 = 100 Mb/s or fiber operation, 0 = 10 Mb/s operation |
| activity | input | 1 | Transmit or receive activity seen in this cycle |
| collision | input | 1 | Collision seen in this cycle |
| pad_out | output | 5 | Output level for each pad |
| pad_oe | output | 5 | Output enable for each pad |
| mgmt_addr | output | 5 | Latched management address |
| cfg_speed100 | output | 1 | Latched speed strap |
| cfg_full_dup | output | 1 | Latched duplex strap |
| cfg_aneg_en | output | 1 | Latched auto-negotiation enable strap |
| cfg_mii_mode | output | 1 | Latched interface mode strap |

## Verification
The bench runs one reset for every one of the 32 pad address patterns. Each reset also applies a different combination of mode straps, so an error in bit order or a swapped strap produces a wrong value that can be seen. After each release, it checks the output-enable timing and then drives all four link and duplex combinations. Because the latched level flips the expected pad level, these checks separate a correct polarity from an inverted one on every pad. Activity is applied at both speeds, which shows whether it went to the right timer. Collision pulses, a retrigger while the LED is lit, and a trigger held through the dark phase test the lit length, the dark length and the lockout. Finally, the pads and straps are toggled after reset to show that the latched values stay fixed.

// File: rtl/strap_led_ctrl.sv
module strap_led_ctrl #(
  parameter int unsigned BLINK_TICKS = 1 << 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] pad_in,
  input  logic       speed_strap,
  input  logic       duplex_strap,
  input  logic       aneg_strap,
  input  logic       ifmode_strap,
  input  logic       link_up,
  input  logic       full_dup,
  input  logic       speed_100,
  input  logic       activity,
  input  logic       collision,
  output logic [4:0] pad_out,
  output logic [4:0] pad_oe,
  output logic [4:0] mgmt_addr,
  output logic       cfg_speed100,
  output logic       cfg_full_dup,
  output logic       cfg_aneg_en,
  output logic       cfg_mii_mode
);
  localparam int unsigned CW = $clog2(BLINK_TICKS + 1);
  localparam logic [CW-1:0] RELOAD = CW'(BLINK_TICKS - 1);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_ON = 2'd1, ST_OFF = 2'd2;

  logic       arm_q, drive_q;
  logic [2:0] trig, blink_on;
  logic [4:0] lit;

  // R1 R2: strap capture while in reset; R3: two-stage drive enable
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mgmt_addr    <= pad_in;
      cfg_speed100 <= speed_strap;
      cfg_full_dup <= duplex_strap;
      cfg_aneg_en  <= aneg_strap;
      cfg_mii_mode <= ifmode_strap;
      arm_q        <= 1'b0;
      drive_q      <= 1'b0;
    end else begin
      arm_q   <= 1'b1;
      drive_q <= arm_q;
    end
  end

  assign trig = {collision, activity & speed_100, activity & ~speed_100};

  for (genvar g = 0; g < 3; g++) begin : g_blink
    logic [1:0]    st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st  <= ST_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          ST_IDLE: if (trig[g]) begin st <= ST_ON; cnt <= RELOAD; end
          ST_ON: begin
            if (trig[g])           cnt <= RELOAD;
            else if (cnt == '0)    begin st <= ST_OFF; cnt <= RELOAD; end
            else                   cnt <= cnt - 1'b1;
          end
          ST_OFF: begin
            if (cnt == '0) st <= ST_IDLE;
            else           cnt <= cnt - 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end

    assign blink_on[g] = (st == ST_ON);

    a_r7_idle_trigger_lights: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && trig[g]) |=> blink_on[g]);
    a_r7_dark_after_lit: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(blink_on[g]) |=> !blink_on[g]);
  end

  assign lit     = {blink_on, full_dup, link_up};
  assign pad_out = lit ^ mgmt_addr;
  assign pad_oe  = {5{drive_q}};

  a_r3_quiet_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pad_oe == 5'b0));
  a_r9_straps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(mgmt_addr) && $stable(cfg_speed100) && $stable(cfg_full_dup)
                      && $stable(cfg_aneg_en) && $stable(cfg_mii_mode)));
  a_r3_drive_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe == 5'h1f) |=> (pad_oe == 5'h1f));
endmodule

// File: tb/strap_led_ctrl_tb_top.sv
module strap_led_ctrl_tb_top;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [4:0] pad_in = 0;
  logic sp_s = 0, du_s = 0, an_s = 0, if_s = 0;
  logic link_up = 0, full_dup = 0, speed_100 = 0, activity = 0, collision = 0;
  logic [4:0] pad_out, pad_oe, mgmt_addr;
  logic c_sp, c_du, c_an, c_if;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  strap_led_ctrl #(.BLINK_TICKS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in),
    .speed_strap(sp_s), .duplex_strap(du_s), .aneg_strap(an_s), .ifmode_strap(if_s),
    .link_up(link_up), .full_dup(full_dup), .speed_100(speed_100),
    .activity(activity), .collision(collision),
    .pad_out(pad_out), .pad_oe(pad_oe), .mgmt_addr(mgmt_addr),
    .cfg_speed100(c_sp), .cfg_full_dup(c_du), .cfg_aneg_en(c_an), .cfg_mii_mode(c_if));

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_pad(logic [4:0] a, logic [4:0] l);
    return l ^ a;
  endfunction

  // lit mask of blink pads only (pads 2..4), static inputs on pads 0/1 are 0
  task automatic chk_blink(string tag, logic [4:0] a, logic [4:0] l);
    chk(tag, pad_out, exp_pad(a, l));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] a;
    logic [3:0] s;
    for (int k = 0; k < 32; k++) begin
      a = 5'(k);
      s = 4'(k * 7 + 3);
      rst_n = 0; pad_in = a; {sp_s, du_s, an_s, if_s} = s;
      link_up = 0; full_dup = 0; activity = 0; collision = 0; speed_100 = 0;
      tick(); tick(); tick();
      chk("R3 oe in reset", pad_oe, 5'h00);
      rst_n = 1;
      tick();
      chk("R3 oe first cycle", pad_oe, 5'h00);
      pad_in = ~a; {sp_s, du_s, an_s, if_s} = ~s;
      tick();
      chk("R3 oe driven", pad_oe, 5'h1f);
      chk("R1 address", mgmt_addr, a);
      chk("R2 straps", {c_sp, c_du, c_an, c_if}, s);
      for (int m = 0; m < 4; m++) begin
        link_up = m[0]; full_dup = m[1];
        #1;
        chk("R4 R5 steady pads", pad_out, exp_pad(a, {3'b000, m[1], m[0]}));
      end
      link_up = 0; full_dup = 0;
      tick();
      chk("R9 address held", mgmt_addr, a);
      chk("R9 straps held", {c_sp, c_du, c_an, c_if}, s);
    end

    // blink tests with address 5'b10100 latched
    a = 5'b10100;
    rst_n = 0; pad_in = a; tick(); tick(); rst_n = 1; tick(); tick();
    chk("R1 address blink cfg", mgmt_addr, a);
    chk_blink("R4 idle pads", a, 5'b00000);

    // R6 10 Mb/s activity -> pad 2, then R7 timing
    speed_100 = 0; activity = 1; tick(); activity = 0;
    for (int c = 0; c < N; c++) begin chk_blink("R6 R7 pad2 lit", a, 5'b00100); tick(); end
    activity = 1;
    for (int c = 0; c < N; c++) begin chk_blink("R7 pad2 dark lockout", a, 5'b00000); tick(); end
    chk_blink("R7 pad2 idle at end of dark", a, 5'b00000);
    tick(); activity = 0;
    chk_blink("R7 pad2 retrigger after dark", a, 5'b00100);
    for (int c = 0; c < 2 * N + 2; c++) tick();
    chk_blink("R7 pad2 settled", a, 5'b00000);

    // R6 100 Mb/s activity -> pad 3 only
    speed_100 = 1; activity = 1; tick(); activity = 0;
    for (int c = 0; c < N; c++) begin chk_blink("R6 pad3 lit", a, 5'b01000); tick(); end
    chk_blink("R6 pad3 dark", a, 5'b00000);
    for (int c = 0; c < N + 2; c++) tick();

    // R7 retrigger while lit extends the lit period
    activity = 1; tick(); activity = 0;
    tick(); tick();
    activity = 1; tick(); activity = 0;
    for (int c = 0; c < N; c++) begin chk_blink("R7 extended lit", a, 5'b01000); tick(); end
    chk_blink("R7 extended then dark", a, 5'b00000);
    for (int c = 0; c < N + 2; c++) tick();

    // R8 collision -> pad 4
    collision = 1; tick(); collision = 0;
    for (int c = 0; c < N; c++) begin chk_blink("R8 pad4 lit", a, 5'b10000); tick(); end
    collision = 1;
    for (int c = 0; c < N; c++) begin chk_blink("R8 pad4 dark", a, 5'b00000); tick(); end
    collision = 0;
    for (int c = 0; c < 3; c++) tick();

    // R9 strap inputs and pads toggled after reset
    pad_in = 5'b01011; {sp_s, du_s, an_s, if_s} = 4'hF;
    tick(); tick();
    chk("R9 address unchanged", mgmt_addr, a);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule